// File: doc/BRIEF.md
# Serial Sampling Converter Output Emulator

This block models the digital side of a sampling converter that is read over 16 serial-clock cycles. It is meant to stand in for the converter as a device-side model or a test target. A master drives an active-low chip select and a serial clock. When chip select falls, the block captures a ready parallel sample word and enables its data pin. It then moves out a fixed-shape frame on the falling edges of the serial clock. A status flag reports whether the emulated sampler is in hold or in track.

Both master signals pass through a synchronizer on a faster system clock, and their edges are detected there. No logic runs on the serial clock itself. The `RES` parameter selects a resolution of 12, 10 or 8 bits. The frame keeps its 16-clock length at every resolution, and the unused slots at the end are filled with zeros.

Top module: `adc_serial_emu`

## Requirements
- R1: After reset, `sdo_o`, `sdo_oe_o` and `hold_o` are all 0.
- R2: A falling edge of `cs_ni` captures `sample_i`, sets `hold_o` to 1 and `sdo_oe_o` to 1, and drives `sdo_o` to 0.
- R3: After the chip-select fall and after serial-clock falling edges 1, 2 and 3, `sdo_o` is 0.
- R4: After falling edge k, for k from 4 to 3+RES, `sdo_o` carries bit (RES+3-k) of the captured sample, most significant bit first. The pin changes only after a serial-clock falling edge or a chip-select edge.
- R5: After falling edges 4+RES through 15, `sdo_o` is 0. This gives 12-RES trailing zeros: none at 12 bits, 2 at 10 bits and 4 at 8 bits.
- R6: Changes on `sample_i` after the chip-select fall do not affect the frame in progress.
- R7: `hold_o` stays 1 through the first 12 rising serial-clock edges of a frame and returns to 0 after the 13th.
- R8: `sdo_oe_o` returns to 0 after the 16th falling serial-clock edge, even if chip select stays low.
- R9: A rise of `cs_ni` before the frame completes ends the frame at once: `hold_o` and `sdo_oe_o` go to 0.
- R10: Serial-clock edges while chip select is high, or after the 16th falling edge, leave all outputs unchanged. `sdo_oe_o` goes to 1 only after a chip-select fall.
- R11: `sdo_o` is 0 whenever `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select from the master |
| sclk_i | input | 1 | Serial clock from the master |
| sample_i | input | RES | Parallel sample word to be captured |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Data pin drive enable (0 = high impedance) |
| hold_o | output | 1 | Sampler status: 1 = hold, 0 = track |

## Verification
The assertions take for granted that each level of `cs_ni` and `sclk_i` lasts longer than the synchronizer depth plus one system cycle. They also assume that a chip-select edge never lands in the same system cycle as a serial-clock edge, and that the serial clock is low when chip select falls. The stimulus meets these conditions by holding every half period of the serial clock for six system cycles and by moving chip select only while the serial clock is low. Two instances at 12 and 8 bits are driven side by side, so the leading, data and trailing slots are compared at both resolutions.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  localparam int unsigned FRAME_CLKS = 16;
  localparam int unsigned TRACK_EDGE = 13;
  localparam int unsigned MAX_RES    = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_DONE
  } frame_st_e;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= RST_VAL;
      else if (i == 0) sync_q[i] <= d_i;
      else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= RST_VAL;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_emu_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_CLKS,
  parameter int unsigned TRACK_AT  = TRACK_EDGE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic hold_o,
  output logic oe_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);

  frame_st_e        st_q;
  logic [CNT_W-1:0] rise_q, fall_q;
  logic             in_frame, rise_ok, fall_ok;

  assign in_frame = (st_q == ST_FRAME);
  assign rise_ok  = in_frame && sclk_rise_i && (rise_q < CNT_W'(TRACK_AT));
  assign fall_ok  = in_frame && sclk_fall_i && (fall_q < CNT_W'(FRAME_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rise_q <= '0;
      fall_q <= '0;
      hold_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (cs_rise_i || (st_q == ST_IDLE && !cs_fall_i)) begin
      // chip select high: counters held clear, back to track
      st_q   <= ST_IDLE;
      rise_q <= '0;
      fall_q <= '0;
      hold_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (cs_fall_i) begin
      st_q   <= ST_FRAME;
      rise_q <= '0;
      fall_q <= '0;
      hold_o <= 1'b1;
      oe_o   <= 1'b1;
    end else begin
      if (rise_ok) begin
        rise_q <= rise_q + 1'b1;
        if (rise_q == CNT_W'(TRACK_AT - 1)) hold_o <= 1'b0;
      end
      if (fall_ok) begin
        fall_q <= fall_q + 1'b1;
        if (fall_q == CNT_W'(FRAME_LEN - 1)) begin
          oe_o <= 1'b0;
          st_q <= ST_DONE;
        end
      end
    end
  end

  assign load_o  = cs_fall_i;
  assign shift_o = fall_ok;
  assign clear_o = cs_rise_i;
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
  import adc_emu_pkg::*;
#(
  parameter int unsigned RES = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic           clear_i,
  input  logic [RES-1:0] sample_i,
  output logic           sdo_o
);
  localparam int unsigned WORD_W = FRAME_CLKS;
  localparam int unsigned TRAIL  = MAX_RES - RES;

  logic [WORD_W-1:0] word_q, load_word;

  // lead-in slot plus three zeros on top, data, then trailing zeros
  assign load_word = WORD_W'(sample_i) << TRAIL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (clear_i) word_q <= '0;
    else if (load_i)  word_q <= load_word;
    else if (shift_i) word_q <= {word_q[WORD_W-2:0], 1'b0};
  end

  assign sdo_o = word_q[WORD_W-1];
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int unsigned RES         = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           sclk_i,
  input  logic [RES-1:0] sample_i,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic           hold_o
);
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic load, shift, clear;

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .d_i(cs_ni), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk_i, .rst_ni, .d_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  adc_frame_ctrl #(.FRAME_LEN(FRAME_CLKS), .TRACK_AT(TRACK_EDGE)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .load_o(load), .shift_o(shift), .clear_o(clear),
    .hold_o(hold_o), .oe_o(sdo_oe_o)
  );

  adc_shift_out #(.RES(RES)) u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .shift_i(shift), .clear_i(clear),
    .sample_i(sample_i), .sdo_o(sdo_o)
  );
endmodule

// File: rtl/adc_emu_chk.sv
module adc_emu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_fall_i,
  input logic cs_rise_i,
  input logic sclk_rise_i,
  input logic sclk_fall_i,
  input logic sdo_i,
  input logic oe_i,
  input logic hold_i
);
  AST_CS_FALL_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (oe_i && hold_i && !sdo_i)); // R2
  AST_SDO_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_i) |-> $past(sclk_fall_i || cs_fall_i || cs_rise_i)); // R4
  AST_TRACK_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |-> $past(sclk_rise_i || cs_rise_i)); // R7
  AST_CS_RISE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> (!oe_i && !hold_i && !sdo_i)); // R9
  AST_OE_ONLY_ON_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> $past(cs_fall_i)); // R10
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !sdo_i); // R11
endmodule

bind adc_serial_emu adc_emu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
  .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
  .sdo_i(sdo_o), .oe_i(sdo_oe_o), .hold_i(hold_o)
);

// File: tb/sim_adc_serial_emu.sv
module sim_adc_serial_emu;
  localparam int HALF = 6;

  typedef struct {
    logic  sdo12;
    logic  sdo8;
    logic  oe;
    logic  hold;
    string req;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0;
  logic [11:0] sample = '0;
  logic        sdo12, oe12, hold12, sdo8, oe8, hold8;
  int          checks = 0, errors = 0;
  exp_t        q[$];
  event        ev_sample;

  always #10 clk = ~clk;

  adc_serial_emu #(.RES(12)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sample_i(sample), .sdo_o(sdo12), .sdo_oe_o(oe12), .hold_o(hold12)
  );

  adc_serial_emu #(.RES(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sample_i(sample[11:4]), .sdo_o(sdo8), .sdo_oe_o(oe8), .hold_o(hold8)
  );

  // expected pin value after f falling edges, for resolution res
  function automatic logic fbit(input int res, input logic [11:0] s, input int f);
    logic [15:0] w;
    w = {4'b0, s & (12'hFFF << (12 - res))};
    return (f >= 16) ? 1'b0 : w[15 - f];
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [11:0] s, input int f, input logic oe,
                      input logic hold, input string req);
    exp_t e;
    e.sdo12 = oe ? fbit(12, s, f) : 1'b0;
    e.sdo8  = oe ? fbit(8, s, f)  : 1'b0;
    e.oe    = oe;
    e.hold  = hold;
    e.req   = req;
    q.push_back(e);
    -> ev_sample;
  endtask

  task automatic cmp(input logic act, input logic exp, input string what, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin : monitor
    forever begin
      @(ev_sample);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(sdo12, e.sdo12, "sdo12", e.req);
        cmp(sdo8,  e.sdo8,  "sdo8",  e.req);
        cmp(oe12,  e.oe,    "oe12",  e.req);
        cmp(oe8,   e.oe,    "oe8",   e.req);
        cmp(hold12, e.hold, "hold12", e.req);
        cmp(hold8,  e.hold, "hold8",  e.req);
      end
    end
  end

  // nclk serial clocks; sample_i inverted before rise swap_at (R6)
  task automatic run_frame(input logic [11:0] s, input int nclk, input int swap_at);
    logic [11:0] held;
    int f;
    held   = s;
    sample = s;
    step(2);
    cs_n = 1'b0;
    step(HALF);
    push(held, 0, 1'b1, 1'b1, "R2 R3");
    for (int k = 1; k <= nclk; k++) begin
      if (k == swap_at) sample = ~s;
      sclk = 1'b1;
      step(HALF);
      f = (k - 1 > 16) ? 16 : k - 1;
      push(held, f, (k - 1) < 16, k < 13, (k == 13) ? "R7" : "R4 R6 R7");
      sclk = 1'b0;
      step(HALF);
      f = (k > 16) ? 16 : k;
      push(held, f, k < 16, k < 13,
           (k <= 3) ? "R3" : (k > 16) ? "R10" : (k == 16) ? "R8" : "R4 R5 R6");
    end
    cs_n = 1'b1;
    step(HALF);
    push(held, 16, 1'b0, 1'b0, (nclk < 16) ? "R9 R11" : "R11");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    step(3);
    push(12'h000, 16, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    step(4);
    push(12'h000, 16, 1'b0, 1'b0, "R1");
    // serial clock toggles with chip select high: no effect
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; step(HALF);
      push(12'h000, 16, 1'b0, 1'b0, "R10");
      sclk = 1'b0; step(HALF);
      push(12'h000, 16, 1'b0, 1'b0, "R10");
    end
    run_frame(12'hA5C, 16, 0);
    run_frame(12'hFFF, 16, 0);
    run_frame(12'h001, 16, 0);
    run_frame(12'h3C9, 16, 5);
    run_frame(12'h8F1, 18, 0);
    run_frame(12'hB6D, 7, 0);
    run_frame(12'h5A3, 14, 0);
    run_frame(12'h765, 16, 2);
    step(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule